// File: doc/BRIEF.md
# Descriptor Chain Fetch Sequencer

This block is the per-channel sequencer that walks linked lists of fixed-size job descriptors in system memory. The host starts a job by writing the address of the first descriptor into the channel's pointer input. The sequencer then reads the whole descriptor in one burst. A descriptor holds a header, seven length/address pairs and a link word. The sequencer hands each pair with a non-zero length to a data mover as a transfer request. When the last pair is done it follows the link word, and it stops when the link is zero.

Pairs in the low slots carry input material. The remaining slots carry results, and these are released only after the execution unit reports that it has finished. Completion is reported once per descriptor or once per chain, as chosen by a configuration input. The report is a one-cycle interrupt pulse. When write-back is enabled, the pulse is preceded by a write of the header, with a DONE flag set, to the descriptor's own base address. If the mover reports an error, the chain stops and the failing transfer address is kept for the host.

Top module: `dcs_chain_seq`

## Requirements
- R1: While idle, a pulse on `ptr_wr_en` latches `ptr_wr_addr` and the block issues one burst read request at that address with `rd_req_len` equal to 16 words.
- R2: Burst beats are placed in order. Beat 0 is the header. Beat 1+2k is the length of pair k and beat 2+2k is its address, for k = 0..6. Beat 15 is the link to the next descriptor.
- R3: Pairs are issued in ascending slot order. A pair with a zero length produces no transfer request, and every request presents that pair's length and address unchanged until `xfer_ack`.
- R4: `xfer_dir` is 0 (input) for slots 0 to 2 and 1 (output) for slots 3 to 6, and `xfer_slot` gives the slot number.
- R5: An output request is issued only after `unit_done` has been high in some cycle since the current descriptor's read request was accepted. A descriptor without output pairs never waits for it.
- R6: After a descriptor, a non-zero link causes a burst read at the link address. A zero link returns the block to idle (`busy` low).
- R7: `cfg_notify_each` (sampled at start) = 1 reports completion after every descriptor. A value of 0 reports it only after the descriptor whose link is zero.
- R8: With `cfg_writeback` (sampled at start) = 1, a completion report first writes the header with bit 24 set to the descriptor's base address, then pulses `irq` for one cycle. With 0, it pulses `irq` only.
- R9: A transfer acknowledged with `xfer_err` = 1 sets `err_valid` and `err_addr` to that transfer's address, pulses `irq`, and ends the chain with no write-back and no further reads. `err_valid` clears at the next start.
- R10: A pulse on `ptr_wr_en` while `busy` is high is ignored, and the running chain continues unchanged.
- R11: After reset the block is idle. `busy`, `irq`, `err_valid`, `rd_req_valid`, `xfer_valid` and `wb_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ptr_wr_en | input | 1 | Host write strobe for the start pointer |
| ptr_wr_addr | input | 32 | First descriptor address |
| cfg_notify_each | input | 1 | 1: report every descriptor, 0: report end of chain |
| cfg_writeback | input | 1 | 1: write header back before interrupt |
| rd_req_valid | output | 1 | Burst read request |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 32 | Burst start address |
| rd_req_len | output | 5 | Burst length in words |
| rd_data_valid | input | 1 | Read beat valid |
| rd_data | input | 32 | Read beat data |
| unit_done | input | 1 | Execution unit finished |
| xfer_valid | output | 1 | Transfer request to the mover |
| xfer_ack | input | 1 | Transfer finished |
| xfer_err | input | 1 | Transfer failed (with `xfer_ack`) |
| xfer_slot | output | 3 | Slot number of the request |
| xfer_dir | output | 1 | 0 input, 1 output |
| xfer_len | output | 32 | Byte count of the request |
| xfer_addr | output | 32 | Memory address of the request |
| wb_valid | output | 1 | Header write-back request |
| wb_ready | input | 1 | Write-back accepted |
| wb_addr | output | 32 | Write-back address |
| wb_data | output | 32 | Header with DONE set |
| irq | output | 1 | One-cycle completion or error pulse |
| busy | output | 1 | Channel active |
| err_valid | output | 1 | Chain ended on a transfer error |
| err_addr | output | 32 | Address of the failed transfer |

## Verification
The bench goes after the following corner cases:
- **Sparse descriptors.** Descriptors with scattered zero-length slots and a descriptor with every slot empty. A scanner that stops at the first empty slot, or issues empty ones, misses or adds requests.
- **Input-only descriptors.** A descriptor with only input pairs runs with `unit_done` never raised. A design that always waits for the unit hangs on it.
- **Early `unit_done`.** `unit_done` arrives during the burst. A design that forgets an early pulse also hangs.
- **Chain-end reporting.** A three-descriptor chain runs in chain-end mode, where a design that reports early writes back the wrong descriptor.
- **Errors.** An error in mid-descriptor must suppress the link, the write-back and the rest of the pairs.
- **Gapped reads.** Read beats arrive with gaps, so a design that counts cycles instead of beats mis-places pair fields.
- **Late host write.** A stray host write during a chain must not redirect the chain.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_FETCH_REQ  = 3'd1,
        ST_FETCH_DATA = 3'd2,
        ST_SCAN       = 3'd3,
        ST_WAIT_UNIT  = 3'd4,
        ST_XFER       = 3'd5,
        ST_WRITEBACK  = 3'd6
    } dcs_state_e;

endpackage

// File: rtl/dcs_desc_buf.sv
module dcs_desc_buf #(
    parameter int DATA_W    = 32,
    parameter int NUM_PAIRS = 7,
    parameter int IDX_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] hdr,
    output logic [DATA_W-1:0] pair_len [NUM_PAIRS],
    output logic [DATA_W-1:0] pair_ptr [NUM_PAIRS],
    output logic [DATA_W-1:0] next_ptr
);
    localparam int DESC_WORDS = 2 * NUM_PAIRS + 2;

    logic [DATA_W-1:0] words_d [DESC_WORDS];
    logic [DATA_W-1:0] words_q [DESC_WORDS];

    always_comb begin
        words_d = words_q;
        if (wr_en) begin
            words_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DESC_WORDS; i++) begin
                words_q[i] <= '0;
            end
        end else begin
            words_q <= words_d;
        end
    end

    // Fixed word layout: header, then length/address per pair, then link.
    assign hdr      = words_q[0];
    assign next_ptr = words_q[DESC_WORDS-1];

    for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
        assign pair_len[k] = words_q[1 + 2*k];
        assign pair_ptr[k] = words_q[2 + 2*k];
    end

    // The write index always addresses an existing word.
    assert_idx_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_idx) < DESC_WORDS));

endmodule

// File: rtl/dcs_slot_scan.sv
module dcs_slot_scan #(
    parameter int DATA_W    = 32,
    parameter int NUM_PAIRS = 7,
    parameter int SLOT_W    = 3
) (
    input  logic [DATA_W-1:0] pair_len [NUM_PAIRS],
    input  logic [SLOT_W-1:0] cursor,
    output logic              found,
    output logic [SLOT_W-1:0] idx
);
    logic [NUM_PAIRS-1:0] cand;

    for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_cand
        assign cand[k] = (|pair_len[k]) && (SLOT_W'(k) >= cursor);
    end

    // Lowest candidate slot wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = NUM_PAIRS - 1; k >= 0; k--) begin
            if (cand[k]) begin
                found = 1'b1;
                idx   = SLOT_W'(k);
            end
        end
    end

endmodule

// File: rtl/dcs_chain_seq.sv
module dcs_chain_seq
    import dcs_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int NUM_PAIRS = 7,
    parameter int NUM_IN    = 3,
    parameter int DONE_BIT  = 24,
    localparam int DESC_WORDS = 2 * NUM_PAIRS + 2,
    localparam int CNT_W      = $clog2(DESC_WORDS),
    localparam int BLEN_W     = $clog2(DESC_WORDS + 1),
    localparam int SLOT_W     = $clog2(NUM_PAIRS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_wr_en,
    input  logic [ADDR_W-1:0] ptr_wr_addr,
    input  logic              cfg_notify_each,
    input  logic              cfg_writeback,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [ADDR_W-1:0] rd_req_addr,
    output logic [BLEN_W-1:0] rd_req_len,
    input  logic              rd_data_valid,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              unit_done,
    output logic              xfer_valid,
    input  logic              xfer_ack,
    input  logic              xfer_err,
    output logic [SLOT_W-1:0] xfer_slot,
    output logic              xfer_dir,
    output logic [DATA_W-1:0] xfer_len,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic              wb_valid,
    input  logic              wb_ready,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data,
    output logic              irq,
    output logic              busy,
    output logic              err_valid,
    output logic [ADDR_W-1:0] err_addr
);

    typedef struct packed {
        dcs_state_e        state;
        logic [ADDR_W-1:0] base;
        logic [CNT_W-1:0]  beat;
        logic [SLOT_W-1:0] cursor;
        logic [SLOT_W-1:0] slot;
        logic              unit_seen;
        logic              each;
        logic              wb;
        logic              irq;
        logic              err_valid;
        logic [ADDR_W-1:0] err_addr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              buf_we;
    logic [DATA_W-1:0] desc_hdr;
    logic [DATA_W-1:0] desc_len [NUM_PAIRS];
    logic [DATA_W-1:0] desc_ptr [NUM_PAIRS];
    logic [DATA_W-1:0] desc_next;
    logic              scan_found;
    logic [SLOT_W-1:0] scan_idx;

    dcs_desc_buf #(
        .DATA_W    (DATA_W),
        .NUM_PAIRS (NUM_PAIRS),
        .IDX_W     (CNT_W)
    ) desc_buf_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (buf_we),
        .wr_idx   (ctl_q.beat),
        .wr_data  (rd_data),
        .hdr      (desc_hdr),
        .pair_len (desc_len),
        .pair_ptr (desc_ptr),
        .next_ptr (desc_next)
    );

    dcs_slot_scan #(
        .DATA_W    (DATA_W),
        .NUM_PAIRS (NUM_PAIRS),
        .SLOT_W    (SLOT_W)
    ) slot_scan_i (
        .pair_len (desc_len),
        .cursor   (ctl_q.cursor),
        .found    (scan_found),
        .idx      (scan_idx)
    );

    logic link_zero;
    logic notify_now;
    assign link_zero  = (desc_next == '0);
    assign notify_now = ctl_q.each || link_zero;

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.irq       = 1'b0;
        ctl_d.unit_seen = ctl_q.unit_seen | unit_done;
        buf_we          = 1'b0;

        case (ctl_q.state)
            ST_IDLE: begin
                if (ptr_wr_en) begin
                    ctl_d.base      = ptr_wr_addr;
                    ctl_d.each      = cfg_notify_each;
                    ctl_d.wb        = cfg_writeback;
                    ctl_d.err_valid = 1'b0;
                    ctl_d.state     = ST_FETCH_REQ;
                end
            end
            ST_FETCH_REQ: begin
                if (rd_req_ready) begin
                    ctl_d.beat      = '0;
                    ctl_d.unit_seen = 1'b0;
                    ctl_d.state     = ST_FETCH_DATA;
                end
            end
            ST_FETCH_DATA: begin
                if (rd_data_valid) begin
                    buf_we = 1'b1;
                    if (ctl_q.beat == CNT_W'(DESC_WORDS - 1)) begin
                        ctl_d.cursor = '0;
                        ctl_d.state  = ST_SCAN;
                    end else begin
                        ctl_d.beat = ctl_q.beat + 1'b1;
                    end
                end
            end
            ST_SCAN: begin
                if (scan_found) begin
                    ctl_d.slot = scan_idx;
                    if ((scan_idx >= SLOT_W'(NUM_IN)) && !ctl_q.unit_seen) begin
                        ctl_d.state = ST_WAIT_UNIT;
                    end else begin
                        ctl_d.state = ST_XFER;
                    end
                end else if (notify_now && ctl_q.wb) begin
                    ctl_d.state = ST_WRITEBACK;
                end else begin
                    ctl_d.irq = notify_now;
                    if (link_zero) begin
                        ctl_d.state = ST_IDLE;
                    end else begin
                        ctl_d.base  = ADDR_W'(desc_next);
                        ctl_d.state = ST_FETCH_REQ;
                    end
                end
            end
            ST_WAIT_UNIT: begin
                if (ctl_q.unit_seen) begin
                    ctl_d.state = ST_XFER;
                end
            end
            ST_XFER: begin
                if (xfer_ack) begin
                    if (xfer_err) begin
                        ctl_d.err_valid = 1'b1;
                        ctl_d.err_addr  = xfer_addr;
                        ctl_d.irq       = 1'b1;
                        ctl_d.state     = ST_IDLE;
                    end else begin
                        ctl_d.cursor = ctl_q.slot + 1'b1;
                        ctl_d.state  = ST_SCAN;
                    end
                end
            end
            ST_WRITEBACK: begin
                if (wb_ready) begin
                    ctl_d.irq = 1'b1;
                    if (link_zero) begin
                        ctl_d.state = ST_IDLE;
                    end else begin
                        ctl_d.base  = ADDR_W'(desc_next);
                        ctl_d.state = ST_FETCH_REQ;
                    end
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rd_req_valid = (ctl_q.state == ST_FETCH_REQ);
    assign rd_req_addr  = ctl_q.base;
    assign rd_req_len   = BLEN_W'(DESC_WORDS);
    assign xfer_valid   = (ctl_q.state == ST_XFER);
    assign xfer_slot    = ctl_q.slot;
    assign xfer_dir     = (ctl_q.slot >= SLOT_W'(NUM_IN));
    assign xfer_len     = desc_len[ctl_q.slot];
    assign xfer_addr    = ADDR_W'(desc_ptr[ctl_q.slot]);
    assign wb_valid     = (ctl_q.state == ST_WRITEBACK);
    assign wb_addr      = ctl_q.base;
    assign wb_data      = desc_hdr | (DATA_W'(1) << DONE_BIT);
    assign irq          = ctl_q.irq;
    assign busy         = (ctl_q.state != ST_IDLE);
    assign err_valid    = ctl_q.err_valid;
    assign err_addr     = ctl_q.err_addr;

    assert_rd_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

    assert_xfer_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid && !xfer_ack |=> xfer_valid && $stable(xfer_addr) && $stable(xfer_len));

    assert_no_empty_xfer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> (xfer_len != '0));

    assert_out_after_unit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid && xfer_dir |-> ctl_q.unit_seen);

    assert_one_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_req_valid, xfer_valid, wb_valid}));

    assert_wb_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr));

    assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_valid) |-> $past(xfer_valid && xfer_ack && xfer_err));

endmodule

// File: tb/dcs_chain_seq_tb_top.sv
`timescale 1ns/1ps
module dcs_chain_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ptr_wr_en = 1'b0;
    logic [31:0] ptr_wr_addr = '0;
    logic        cfg_notify_each = 1'b0;
    logic        cfg_writeback = 1'b0;
    logic        rd_req_valid;
    logic        rd_req_ready = 1'b1;
    logic [31:0] rd_req_addr;
    logic [4:0]  rd_req_len;
    logic        rd_data_valid = 1'b0;
    logic [31:0] rd_data = '0;
    logic        unit_done = 1'b0;
    logic        xfer_valid;
    logic        xfer_ack = 1'b0;
    logic        xfer_err = 1'b0;
    logic [2:0]  xfer_slot;
    logic        xfer_dir;
    logic [31:0] xfer_len;
    logic [31:0] xfer_addr;
    logic        wb_valid;
    logic        wb_ready = 1'b0;
    logic [31:0] wb_addr;
    logic [31:0] wb_data;
    logic        irq;
    logic        busy;
    logic        err_valid;
    logic [31:0] err_addr;

    always #4 clk = ~clk;

    dcs_chain_seq dut_i (
        .clk(clk), .rst_n(rst_n),
        .ptr_wr_en(ptr_wr_en), .ptr_wr_addr(ptr_wr_addr),
        .cfg_notify_each(cfg_notify_each), .cfg_writeback(cfg_writeback),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_addr(rd_req_addr), .rd_req_len(rd_req_len),
        .rd_data_valid(rd_data_valid), .rd_data(rd_data),
        .unit_done(unit_done),
        .xfer_valid(xfer_valid), .xfer_ack(xfer_ack), .xfer_err(xfer_err),
        .xfer_slot(xfer_slot), .xfer_dir(xfer_dir),
        .xfer_len(xfer_len), .xfer_addr(xfer_addr),
        .wb_valid(wb_valid), .wb_ready(wb_ready),
        .wb_addr(wb_addr), .wb_data(wb_data),
        .irq(irq), .busy(busy), .err_valid(err_valid), .err_addr(err_addr)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    logic [31:0] mem [0:1023];

    // Expected event stream: kind 1 read, 2 transfer, 3 write-back, 4 irq.
    int exp_kind [$];
    int exp_a [$];
    int exp_b [$];
    int exp_c [$];

    int pend = 0, beat = 0, rd_base = 0;
    bit gap_mode = 0, gap_tog = 0;
    int unit_delay = -1, unit_cnt = 0;
    bit unit_given = 0;
    int xwait = 0, xdelay = 0;
    bit use_err = 0;
    int err_ptr = 0;

    function automatic int widx(input int a);
        return (a >>> 2) & 1023;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input int k, input int a, input int b, input int c);
        exp_kind.push_back(k); exp_a.push_back(a);
        exp_b.push_back(b);    exp_c.push_back(c);
    endtask

    task automatic got(input int k, input int a, input int b, input int c, input string req);
        int ek, ea, eb, ec;
        n_checks++;
        if (exp_kind.size() == 0) begin
            n_fail++;
            $display("FAIL %s unexpected event actual kind=%0d a=%h b=%h expected none", req, k, a, b);
        end else begin
            ek = exp_kind.pop_front(); ea = exp_a.pop_front();
            eb = exp_b.pop_front();    ec = exp_c.pop_front();
            if (ek != k || ea != a || eb != b || ec != c) begin
                n_fail++;
                $display("FAIL %s actual kind=%0d a=%h b=%h c=%0d expected kind=%0d a=%h b=%h c=%0d",
                         req, k, a, b, c, ek, ea, eb, ec);
            end
        end
    endtask

    task automatic put_desc(input int base, input int hdr, input int nxt);
        mem[widx(base)] = hdr;
        for (int i = 1; i < 15; i++) mem[widx(base) + i] = '0;
        mem[widx(base) + 15] = nxt;
    endtask

    task automatic put_pair(input int base, input int k, input int len, input int ptr);
        mem[widx(base) + 1 + 2*k] = len;
        mem[widx(base) + 2 + 2*k] = ptr;
    endtask

    // Behavioural walk of the chain as memory describes it.
    task automatic build_model(input int start, input bit each, input bit wb);
        int a, w, len, ptr, nxt, guard;
        bit aborted;
        a = start; aborted = 0; guard = 0;
        while (guard < 32) begin
            guard++;
            w = widx(a);
            push(1, a, 16, 0);
            for (int k = 0; k < 7; k++) begin
                len = int'(mem[w + 1 + 2*k]);
                ptr = int'(mem[w + 2 + 2*k]);
                if (len != 0) begin
                    push(2, ptr, len, k*2 + ((k >= 3) ? 1 : 0));
                    if (use_err && ptr == err_ptr) begin
                        push(4, 0, 0, 0);
                        aborted = 1;
                        break;
                    end
                end
            end
            if (aborted) break;
            nxt = int'(mem[w + 15]);
            if (each || nxt == 0) begin
                if (wb) push(3, a, int'(mem[w]) | (1 << 24), 0);
                push(4, 0, 0, 0);
            end
            if (nxt == 0) break;
            a = nxt;
        end
    endtask

    // Memory, mover and unit responders, plus event comparison, off the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq) got(4, 0, 0, 0, "R8 R9 irq pulse");
            unit_done = 1'b0;
            if (unit_cnt > 0) begin
                unit_cnt--;
                if (unit_cnt == 0) begin
                    unit_done  = 1'b1;
                    unit_given = 1'b1;
                end
            end
            if (pend > 0) begin
                if (gap_mode && !gap_tog) begin
                    rd_data_valid = 1'b0;
                    gap_tog = 1'b1;
                end else begin
                    rd_data_valid = 1'b1;
                    rd_data = mem[widx(rd_base) + beat];
                    beat++; pend--; gap_tog = 1'b0;
                end
            end else begin
                rd_data_valid = 1'b0;
            end
            if (rd_req_valid && pend == 0) begin
                got(1, int'(rd_req_addr), int'(rd_req_len), 0, "R1 R6 burst fetch");
                pend = 16; beat = 0; rd_base = int'(rd_req_addr); gap_tog = 1'b0;
                unit_given = 1'b0;
                unit_cnt = unit_delay;
            end
            if (xfer_ack) begin
                xfer_ack = 1'b0;
                xfer_err = 1'b0;
            end else if (xfer_valid) begin
                if (xwait >= xdelay) begin
                    got(2, int'(xfer_addr), int'(xfer_len), int'(xfer_slot)*2 + int'(xfer_dir),
                        "R2 R3 R4 transfer");
                    if (xfer_dir) check(unit_given, "R5 output before unit_done", 0, 1);
                    xfer_ack = 1'b1;
                    xfer_err = use_err && (int'(xfer_addr) == err_ptr);
                    xwait = 0;
                end else begin
                    xwait++;
                end
            end
            if (wb_ready) begin
                wb_ready = 1'b0;
            end else if (wb_valid) begin
                got(3, int'(wb_addr), int'(wb_data), 0, "R7 R8 write-back");
                wb_ready = 1'b1;
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    task automatic run_chain(input int start, input bit each, input bit wb, input bit gap,
                             input int udelay, input bit err_on, input int eptr,
                             input int inject_at, input string name);
        use_err = err_on; err_ptr = eptr;
        gap_mode = gap; xdelay = gap ? 2 : 0;
        unit_delay = udelay;
        build_model(start, each, wb);
        @(negedge clk);
        cfg_notify_each = each; cfg_writeback = wb;
        ptr_wr_en = 1'b1; ptr_wr_addr = start;
        @(negedge clk);
        ptr_wr_en = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (inject_at > 0 && i == inject_at) begin
                check(busy, "R10 channel busy at stray write", int'(busy), 1);
                ptr_wr_en = 1'b1; ptr_wr_addr = 32'h0000_0700;
            end else begin
                ptr_wr_en = 1'b0;
            end
            if (!busy && i > 2) break;
        end
        repeat (3) @(negedge clk);
        check(!busy, {"R6 idle after ", name}, int'(busy), 0);
        check(exp_kind.size() == 0, {"R6 R7 missing events in ", name}, exp_kind.size(), 0);
        exp_kind.delete(); exp_a.delete(); exp_b.delete(); exp_c.delete();
        check(err_valid == err_on, {"R9 err_valid after ", name}, int'(err_valid), int'(err_on));
        if (err_on) check(err_addr == eptr, "R9 err_addr", int'(err_addr), eptr);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;

        // A: every slot used, terminal.
        put_desc(32'h100, 32'h0012_0034, 0);
        for (int k = 0; k < 7; k++) put_pair(32'h100, k, 8*(k+1), 32'hA000_0000 + k*32'h40);
        // B -> C -> D: sparse, empty, outputs only.
        put_desc(32'h200, 32'h0055_0001, 32'h300);
        put_pair(32'h200, 0, 16, 32'hB000_0000);
        put_pair(32'h200, 2, 24, 32'hB000_0100);
        put_pair(32'h200, 5, 40, 32'hB000_0200);
        put_desc(32'h300, 32'h0055_0002, 32'h400);
        put_desc(32'h400, 32'h0055_0003, 0);
        put_pair(32'h400, 3, 64, 32'hD000_0000);
        put_pair(32'h400, 4, 12, 32'hD000_0040);
        // E: inputs only.
        put_desc(32'h500, 32'h0077_0000, 0);
        put_pair(32'h500, 0, 4, 32'hE000_0000);
        put_pair(32'h500, 1, 20, 32'hE000_0010);
        // F: error on slot 1, link must not be followed.
        put_desc(32'h600, 32'h0099_0000, 32'h100);
        put_pair(32'h600, 0, 8, 32'hF000_0000);
        put_pair(32'h600, 1, 8, 32'hF000_0100);
        put_pair(32'h600, 3, 8, 32'hF000_0200);
        // Target of the stray write: must never be fetched.
        put_desc(32'h700, 32'h0011_0000, 0);
        put_pair(32'h700, 0, 4, 32'h7000_0000);

        repeat (3) @(negedge clk);
        // R11: reset state.
        check(!busy, "R11 busy in reset", int'(busy), 0);
        check(!irq && !err_valid, "R11 irq/err in reset", int'({irq, err_valid}), 0);
        check(!rd_req_valid && !xfer_valid && !wb_valid, "R11 requests in reset",
              int'({rd_req_valid, xfer_valid, wb_valid}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy, "R11 idle after reset", int'(busy), 0);

        run_chain(32'h100, 1, 1, 0, 30, 0, 0, 0, "full descriptor");
        run_chain(32'h200, 0, 1, 1, 20, 0, 0, 10, "chain end notify");
        run_chain(32'h200, 1, 0, 0, 1, 0, 0, 0, "per descriptor irq");
        run_chain(32'h500, 0, 1, 1, -1, 0, 0, 0, "inputs only");
        run_chain(32'h600, 1, 1, 0, 5, 1, 32'hF000_0100, 0, "transfer error");
        run_chain(32'h100, 0, 0, 1, 3, 0, 0, 0, "restart after error");

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule